// File: doc/BRIEF.md
# Configurable Serial Line Receiver

This block turns one asynchronous serial input line into received words. The frame format is chosen at run time by a 31-bit setup word shared with the matching transmitter. The setup word holds the number of system clocks per bit, the word length (5 to 8 bits), one or two stop bits, and a parity mode. The parity mode is one of none, even, odd, fixed one or fixed zero. The raw line first passes through a two-stage synchronizer. A falling edge starts a frame. The start bit is confirmed half a bit later, and every later bit is taken at its centre.

Each received word is presented for exactly one clock on a valid strobe. During that clock the block also reports a framing error, a parity error and a break. A break is a frame whose every sampled position was low. After reset, and after any frame whose stop position was low, the receiver accepts no new start bit until the line has been high for a full bit time. A held-low line therefore yields one break report and not a stream of words. The setup word is captured when a start edge is seen, so it may change between frames without corrupting a frame in flight.

Top module: `serial_rx`

## Requirements
- R1: The line input passes through two clocked stages before any decision uses it. A frame whose start edge is applied just before clock edge k is detected at edge k+2.
- R2: `valid_o` is high for exactly one clock per received frame. When `valid_o` is low, `data_o`, `frame_err_o`, `parity_err_o` and `break_o` are all zero.
- R3: With B clocks per bit and start detection at edge k+2, the start bit is re-checked at edge k+2+floor(B/2), and each later bit is sampled B clocks after the previous one. A low pulse that has ended by the re-check is discarded with no output. For a frame of m positions after the start bit, `valid_o` rises at edge k+2+floor(B/2)+m*B.
- R4: Setup word layout. Bits [23:0] give B, which must be at least 4. Bit 24 is the parity kind and bit 25 is the fixed-parity select. Bit 26 enables parity and bit 27 selects two stop bits. Bits [29:28] give the length code: 0, 1, 2 and 3 mean 8, 7, 6 and 5 data bits. Bit 30 has no effect on reception.
- R5: Data bits arrive least significant first. Words shorter than 8 bits are right-aligned in `data_o`, and the unused upper bits are zero.
- R6: When parity is enabled, the block compares the received parity bit with an expected value. With fixed select 0, kind 1 gives even parity: the data ones plus the parity bit form an even count. Kind 0 with fixed select 0 gives odd parity. With fixed select 1, the expected bit equals the kind bit. A mismatch sets `parity_err_o`, and with parity disabled the flag stays 0.
- R7: A low level at the stop position sets `frame_err_o`. With two stop bits, both positions are checked and a low level in either one sets the flag.
- R8: `break_o` is set when the start, data, parity (if enabled) and stop positions were all sampled low. It is always reported together with `frame_err_o` and zero data. An all-zero word with a high stop bit is not a break.
- R9: After reset, and after a frame with `frame_err_o` set, a falling edge is ignored until the line has been sampled high for B consecutive clocks.
- R10: A new start edge may follow the end of the last stop bit at once, with no idle gap, when the previous frame had no framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| setup_i | input | 31 | Frame format and bit period (layout in R4) |
| rx_i | input | 1 | Raw serial line, idle high |
| valid_o | output | 1 | One-clock strobe for a received frame |
| data_o | output | 8 | Received word, right-aligned |
| frame_err_o | output | 1 | Stop position found low |
| parity_err_o | output | 1 | Parity bit did not match the configured mode |
| break_o | output | 1 | Every sampled position of the frame was low |

## Verification
Frames are sent at an even bit period and at an odd one. This separates a correct half-bit offset from an off-by-one, because the strobe cycle is predicted exactly and compared on every clock. The bench covers each word length and each parity mode with both correct and wrong parity bits, so the parity kind and the fixed value cannot be swapped without notice. It sends a second stop bit that is low, a low single stop bit, and an all-zero word with good stops. These tell a framing error apart from a break. A held-low line after reset, a break followed by more low time, a short glitch and back-to-back frames show when a falling edge is ignored and when it starts a frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUSH,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  // Format fields of the setup word, most significant field first.
  typedef struct packed {
    logic [1:0] len_code;
    logic       two_stop;
    logic       par_en;
    logic       par_fixed;
    logic       par_kind;
  } fmt_t;

  localparam int FMT_W = $bits(fmt_t);

  // Number of data bits for a length code: 0 -> 8 down to 3 -> 5.
  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  // Shift register fills from the top; move the word down to bit 0.
  function automatic logic [7:0] align_word(input logic [7:0] sr, input logic [1:0] code);
    return sr >> code;
  endfunction

  // Parity bit that a correct frame carries for an aligned word.
  function automatic logic expect_parity(input logic [7:0] word, input fmt_t f);
    if (f.par_fixed) return f.par_kind;
    return f.par_kind ? (^word) : ~(^word);
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) chain <= '0;
        else       chain <= din_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din_i};
      end
    end
  endgenerate

  assign dout_o = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i)            cnt <= '0;
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int BAUD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              line_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  fmt_t              fmt_i,
  input  logic              expired_i,
  output logic              tmr_load_o,
  output logic [BAUD_W-1:0] tmr_val_o,
  output logic              start_seen_o,
  output logic [3:0]        cur_len_o,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              break_o
);
  rx_state_e         state;
  fmt_t              cfg;
  logic [BAUD_W-1:0] cfg_baud;
  logic [7:0]        sr;
  logic [3:0]        bit_cnt;
  logic              par_bit;
  logic              stop_bad;
  logic              all_low;

  logic [7:0] word_aligned;
  logic       par_bad;
  logic       finishing;
  logic       stop_fail;
  logic       last_low;

  assign word_aligned = align_word(sr, cfg.len_code);
  assign par_bad      = cfg.par_en && (par_bit != expect_parity(word_aligned, cfg));
  assign finishing    = expired_i && ((state == ST_STOP1 && !cfg.two_stop) || state == ST_STOP2);
  assign stop_fail    = ((state == ST_STOP2) ? stop_bad : 1'b0) | ~line_i;
  assign last_low     = all_low & ~line_i;
  assign start_seen_o = (state == ST_IDLE) && !line_i;
  assign cur_len_o    = word_bits(cfg.len_code);

  // Timer reload: full bit while waiting for idle or inside a frame,
  // half a bit when a start edge is first seen.
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = cfg_baud - 1'b1;
    case (state)
      ST_HUSH: if (!line_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = baud_i - 1'b1;
      end
      ST_IDLE: if (!line_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = (baud_i >> 1) - 1'b1;
      end
      default: tmr_load_o = expired_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state        <= ST_HUSH;
      cfg          <= '0;
      cfg_baud     <= '0;
      sr           <= '0;
      bit_cnt      <= '0;
      par_bit      <= 1'b0;
      stop_bad     <= 1'b0;
      all_low      <= 1'b0;
      valid_o      <= 1'b0;
      data_o       <= '0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      break_o      <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      data_o       <= '0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      break_o      <= 1'b0;
      case (state)
        ST_HUSH: if (line_i && expired_i) state <= ST_IDLE;
        ST_IDLE: if (!line_i) begin
          state    <= ST_START;
          cfg      <= fmt_i;
          cfg_baud <= baud_i;
          sr       <= '0;
          bit_cnt  <= '0;
          par_bit  <= 1'b0;
          stop_bad <= 1'b0;
          all_low  <= 1'b1;
        end
        ST_START: if (expired_i) state <= line_i ? ST_IDLE : ST_DATA;
        ST_DATA: if (expired_i) begin
          sr      <= {line_i, sr[7:1]};
          all_low <= last_low;
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == word_bits(cfg.len_code) - 4'd1)
            state <= cfg.par_en ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (expired_i) begin
          par_bit <= line_i;
          all_low <= last_low;
          state   <= ST_STOP1;
        end
        ST_STOP1: if (expired_i && cfg.two_stop) begin
          stop_bad <= ~line_i;
          all_low  <= last_low;
          state    <= ST_STOP2;
        end
        ST_STOP2: ;
        default: state <= ST_HUSH;
      endcase
      if (finishing) begin
        valid_o      <= 1'b1;
        data_o       <= word_aligned;
        frame_err_o  <= stop_fail;
        parity_err_o <= par_bad;
        break_o      <= last_low;
        state        <= stop_fail ? ST_HUSH : ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int BAUD_W  = 24,
  parameter int SYNC_N  = 2,
  localparam int SETUP_W = BAUD_W + FMT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic               rx_i,
  output logic               valid_o,
  output logic [7:0]         data_o,
  output logic               frame_err_o,
  output logic               parity_err_o,
  output logic               break_o
);
  logic              line_s;
  logic              tmr_load;
  logic [BAUD_W-1:0] tmr_val;
  logic              tmr_expired;
  logic              start_seen;
  logic [3:0]        cur_len;
  logic [BAUD_W-1:0] baud_in;
  fmt_t              fmt_in;
  logic              unused_flow;

  assign baud_in     = setup_i[BAUD_W-1:0];
  assign fmt_in      = fmt_t'(setup_i[BAUD_W+FMT_W-1:BAUD_W]);
  assign unused_flow = setup_i[SETUP_W-1];

  serial_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .din_i (rx_i),
    .dout_o(line_s)
  );

  serial_rx_timer #(.W(BAUD_W)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_expired)
  );

  serial_rx_frame #(.BAUD_W(BAUD_W)) u_frame (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .line_i      (line_s),
    .baud_i      (baud_in),
    .fmt_i       (fmt_in),
    .expired_i   (tmr_expired),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .start_seen_o(start_seen),
    .cur_len_o   (cur_len),
    .valid_o     (valid_o),
    .data_o      (data_o),
    .frame_err_o (frame_err_o),
    .parity_err_o(parity_err_o),
    .break_o     (break_o)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic       rx_i,
  input logic       start_seen,
  input logic [3:0] cur_len,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       break_o
);
  // R1: a detected start must come from a low level two clocks earlier
  p_sync_two_stage_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    start_seen |-> !$past(rx_i, 2));

  // R2: the strobe never lasts two clocks
  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R2: outputs are quiet outside the strobe
  p_quiet_outputs_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> (data_o == 8'h00) && !frame_err_o && !parity_err_o && !break_o);

  // R5: no data bit above the configured word length
  p_right_aligned_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> ((data_o >> cur_len) == 8'h00));

  // R8: a break also reports a framing error and an empty word
  p_break_frame_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && break_o) |-> (frame_err_o && data_o == 8'h00));

  // R9: no word appears on the clock right after reset
  p_reset_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !valid_o);
endmodule

bind serial_rx serial_rx_checker u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .rx_i        (rx_i),
  .start_seen  (start_seen),
  .cur_len     (cur_len),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .frame_err_o (frame_err_o),
  .parity_err_o(parity_err_o),
  .break_o     (break_o)
);

// File: tb/test_serial_rx.sv
`timescale 1ns/1ps
module test_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [30:0] setup = '0;
  logic        rx = 1'b0;
  logic        valid;
  logic [7:0]  data;
  logic        fe, pe, bk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R9";

  typedef struct {
    int         at;
    logic [7:0] d;
    logic       fe;
    logic       pe;
    logic       bk;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rx i_serial_rx (
    .clk_i(clk), .rst_i(rst), .setup_i(setup), .rx_i(rx),
    .valid_o(valid), .data_o(data), .frame_err_o(fe),
    .parity_err_o(pe), .break_o(bk)
  );

  function automatic logic [30:0] mk_setup(input int b, input int nb, input bit two,
                                           input bit pen, input bit fixed, input bit kind);
    logic [1:0] code;
    code = 2'(8 - nb);
    return {1'b0, code, two, pen, fixed, kind, 24'(b)};
  endfunction

  // parity bit a correct sender would place
  function automatic logic good_par(input logic [7:0] d, input int nb,
                                    input bit fixed, input bit kind);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    if (fixed) return kind;
    if (kind)  return logic'(ones % 2);
    return logic'(1 - (ones % 2));
  endfunction

  // Called at a negedge; drives one frame and queues the expected report.
  task automatic send_frame(input int b, input int nb, input logic [7:0] d,
                            input bit pen, input bit fixed, input bit kind, input logic pbit,
                            input int nstop, input logic st1, input logic st2, input string tag);
    exp_t e;
    logic [7:0] dm;
    int m;
    dm = d & 8'((1 << nb) - 1);
    m  = nb + (pen ? 1 : 0) + nstop;
    e.at  = cyc + 3 + b / 2 + m * b;
    e.d   = dm;
    e.fe  = !st1 || (nstop == 2 && !st2);
    e.pe  = pen && (pbit != good_par(dm, nb, fixed, kind));
    e.bk  = (dm == 8'h00) && (!pen || !pbit) && !st1 && (nstop < 2 || !st2);
    if (e.bk) e.d = 8'h00;
    e.tag = tag;
    expq.push_back(e);
    rx = 1'b0; repeat (b) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = dm[i]; repeat (b) @(negedge clk);
    end
    if (pen) begin
      rx = pbit; repeat (b) @(negedge clk);
    end
    rx = st1; repeat (b) @(negedge clk);
    if (nstop == 2) begin
      rx = st2; repeat (b) @(negedge clk);
    end
    rx = 1'b1;
  endtask

  task automatic idle(input int n);
    rx = 1'b1; repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (expq.size() > 0 && expq[0].at == cyc) begin
        tests++;
        if (!valid || data !== expq[0].d || fe !== expq[0].fe ||
            pe !== expq[0].pe || bk !== expq[0].bk) begin
          fails++;
          $display("FAIL %s: got v=%b d=%h fe=%b pe=%b bk=%b exp v=1 d=%h fe=%b pe=%b bk=%b",
                   expq[0].tag, valid, data, fe, pe, bk,
                   expq[0].d, expq[0].fe, expq[0].pe, expq[0].bk);
        end
        void'(expq.pop_front());
      end else if (valid || data !== 8'h00 || fe || pe || bk) begin
        tests++;
        fails++;
        $display("FAIL %s R2: unexpected output v=%b d=%h fe=%b pe=%b bk=%b exp all zero",
                 cur_tag, valid, data, fe, pe, bk);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    setup = mk_setup(16, 8, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if (valid || data !== 8'h00 || fe || pe || bk) begin
      fails++;
      $display("FAIL R2 R9: reset state v=%b d=%h exp v=0 d=00", valid, data);
    end
    // R9: line low after reset gives nothing
    cur_tag = "R9";
    repeat (48) @(negedge clk);
    idle(32);

    // R3 R5: 8N1 at even period, then back to back (R10)
    cur_tag = "R3";
    send_frame(16, 8, 8'hA5, 0, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R3 R5 8N1");
    send_frame(16, 8, 8'h3C, 0, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R10 back-to-back");
    idle(16);

    // R6 R4: 7 bits even parity, correct
    setup = mk_setup(16, 7, 0, 1, 0, 1);
    send_frame(16, 7, 8'h5A, 1, 0, 1, good_par(8'h5A, 7, 0, 1), 1, 1'b1, 1'b1, "R6 even ok");
    send_frame(16, 7, 8'h5B, 1, 0, 1, ~good_par(8'h5B, 7, 0, 1), 1, 1'b1, 1'b1, "R6 even bad");
    idle(16);

    // R3 R5 R6: odd period, 5 bits odd parity, upper bits dropped
    setup = mk_setup(11, 5, 0, 1, 0, 0);
    send_frame(11, 5, 8'hF5, 1, 0, 0, good_par(8'h15, 5, 0, 0), 1, 1'b1, 1'b1, "R5 R6 odd ok");
    send_frame(11, 5, 8'h0E, 1, 0, 0, ~good_par(8'h0E, 5, 0, 0), 1, 1'b1, 1'b1, "R6 odd bad");
    idle(11);

    // R6: mark and space
    setup = mk_setup(16, 6, 0, 1, 1, 1);
    send_frame(16, 6, 8'h2B, 1, 1, 1, 1'b1, 1, 1'b1, 1'b1, "R6 mark ok");
    send_frame(16, 6, 8'h2B, 1, 1, 1, 1'b0, 1, 1'b1, 1'b1, "R6 mark bad");
    setup = mk_setup(16, 6, 0, 1, 1, 0);
    send_frame(16, 6, 8'h11, 1, 1, 0, 1'b1, 1, 1'b1, 1'b1, "R6 space bad");
    send_frame(16, 6, 8'h11, 1, 1, 0, 1'b0, 1, 1'b1, 1'b1, "R6 space ok");
    idle(16);

    // R4: flow-control bit set has no effect
    setup = mk_setup(16, 8, 0, 0, 0, 0) | 31'h4000_0000;
    send_frame(16, 8, 8'h69, 0, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R4 bit30 ignored");
    idle(16);

    // R7: two stops, second low; then one stop low
    setup = mk_setup(16, 8, 1, 0, 0, 0);
    send_frame(16, 8, 8'hC3, 0, 0, 0, 1'b0, 2, 1'b1, 1'b0, "R7 second stop low");
    idle(48);
    send_frame(16, 8, 8'h77, 0, 0, 0, 1'b0, 2, 1'b1, 1'b1, "R7 two stops ok");
    idle(16);
    setup = mk_setup(16, 8, 0, 0, 0, 0);
    send_frame(16, 8, 8'h96, 0, 0, 0, 1'b0, 1, 1'b0, 1'b0, "R7 stop low");
    idle(48);

    // R8 R9: break, line kept low, then recovery
    cur_tag = "R8";
    send_frame(16, 8, 8'h00, 0, 0, 0, 1'b0, 1, 1'b0, 1'b0, "R8 break");
    rx = 1'b0; repeat (200) @(negedge clk);
    idle(48);
    send_frame(16, 8, 8'h81, 0, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R9 after break");
    idle(16);

    // R8: zero word with good stop is not a break
    setup = mk_setup(16, 7, 0, 1, 0, 1);
    send_frame(16, 7, 8'h00, 1, 0, 1, 1'b0, 1, 1'b1, 1'b1, "R8 zero not break");
    idle(16);

    // R3: glitch rejected, then normal frame
    cur_tag = "R3";
    setup = mk_setup(16, 8, 0, 0, 0, 0);
    rx = 1'b0; repeat (3) @(negedge clk);
    idle(48);
    send_frame(16, 8, 8'h42, 0, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R3 after glitch");
    idle(40);

    if (expq.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL R2: %0d expected words never seen, expected 0", expq.size());
    end
    finish_run();
  end
endmodule